// File: doc/BRIEF.md
# Audio Receiver Status and Interrupt Registers

This block collects eight status signals from the front end of a serial digital audio receiver. It presents them as one read-only status byte on a simple register bus and raises a single active-high interrupt line. Two of the signals are error pulses: the channel-status CRC failure and the biphase/parity failure. Each of these is held in a sticky bit until software reads the status byte. The other six are live conditions: validity, emphasis, non-audio, non-audio preamble, no stream and PLL lock. The status byte shows their present value, and they request an interrupt only when they change.

Every bit has a pending flag. An error pulse or a change of state sets the flag, and a read of the status byte clears it. A writable enable byte uses the same bit positions and selects which pending flags drive the interrupt. For the non-audio bit there is one more trigger: a change in the reported non-audio kind while the stream is non-audio also sets its pending flag.

Top module: `rx_status_irq_regs`

## Requirements
- R1: After reset every pending flag and sticky bit is 0, the enable byte reads 0x00 and `irq_o` is low.
- R2: The status byte is read at address 0x18, and a write to that address has no effect. The enable byte is read and written at address 0x19. A read of any other address returns 0x00.
- R3: Status bit positions from bit 7 down to bit 0 are: validity, emphasis, non-audio, non-audio preamble, CRC error, no stream, biphase/parity error, lock. The enable byte uses the same positions.
- R4: A one-cycle pulse on `crc_err_i` (bit 3) or `frame_err_i` (bit 1) sets the matching status bit. The bit stays 1 until the status byte is read, and that read clears it.
- R5: Bits 7, 6, 5, 4, 2 and 0 show the live level of their condition inputs.
- R6: A change of a condition input in either direction sets that bit's pending flag. A read of the status byte clears all pending flags. A condition that does not change after such a read raises no new interrupt.
- R7: A change of `nonaudio_kind_i` while `nonaudio_i` is 1 sets the pending flag of bit 5. A change of the kind while `nonaudio_i` is 0 has no effect.
- R8: `irq_o` is 1 exactly when some bit has its pending flag set and its enable bit at 1. An enable bit of 0 blocks that bit.
- R9: An error pulse or a condition change in the same cycle as a clearing read wins. The flag and the sticky bit stay set after that read.
- R10: A read of the enable byte clears neither pending flags nor sticky bits.

Signal timing: inputs are sampled on the rising edge of `clk`. Pending flags, sticky bits and the enable byte change on that edge, and `irq_o` follows them in the same cycle. `bus_rdata_o` is combinational from the current state while `bus_rd_i` is high, and is 0x00 when `bus_rd_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 7 | Register address |
| bus_rd_i | input | 1 | Read strobe; a status read clears on the clock edge |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, 0x00 when no read is in progress |
| validity_i | input | 1 | Validity flag of the received stream |
| emphasis_i | input | 1 | Pre-emphasis present |
| nonaudio_i | input | 1 | Channel status marks the payload as non-audio |
| nonaudio_kind_i | input | 2 | Kind of non-audio payload |
| preamble_i | input | 1 | Non-audio preamble detected |
| crc_err_i | input | 1 | One-cycle pulse on a channel-status CRC failure |
| no_stream_i | input | 1 | No input stream present |
| frame_err_i | input | 1 | One-cycle pulse on a biphase or parity failure |
| lock_i | input | 1 | PLL locked |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
Every condition input is toggled alone. Each must show up only at its own bit position, and a read followed by idle cycles must bring no new interrupt: this separates change detection from level detection. The error pulses are issued one by one and then together, which separates sticky latching from a live view. The non-audio kind is changed once with the stream non-audio and once with it audio, to show that the extra trigger depends on that level. A pulse placed in the very cycle of a clearing read shows whether the event or the clear has priority. Enable patterns with one bit set and with all bits clear show that masking works per bit.

// File: rtl/rxsi_pkg.sv
package rxsi_pkg;
  localparam int NBITS   = 8;
  localparam int B_VALID = 7;
  localparam int B_EMPH  = 6;
  localparam int B_NAUD  = 5;
  localparam int B_PREAM = 4;
  localparam int B_CRC   = 3;
  localparam int B_NOSTR = 2;
  localparam int B_FRAME = 1;
  localparam int B_LOCK  = 0;

  localparam logic [NBITS-1:0] STICKY_MAP = (NBITS'(1) << B_CRC) | (NBITS'(1) << B_FRAME);

  function automatic logic irq_reduce(input logic [NBITS-1:0] pend,
                                      input logic [NBITS-1:0] en);
    return |(pend & en);
  endfunction

  function automatic logic next_flag(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/rxsi_bit_cell.sv
module rxsi_bit_cell #(
  parameter bit STICKY = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  input  logic extra_chg_i,
  input  logic clr_i,
  output logic view_o,
  output logic pend_o
);
  import rxsi_pkg::*;

  logic set_evt;
  logic pend_q;

  generate
    if (STICKY) begin : g_sticky
      logic held_q;
      assign set_evt = raw_i;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held_q <= 1'b0;
        else        held_q <= next_flag(held_q, raw_i, clr_i);
      end
      assign view_o = held_q;

      assert_sticky_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (held_q && !clr_i) |=> held_q);
      assert_sticky_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !raw_i) |=> !held_q);
    end else begin : g_level
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= raw_i;
      end
      assign set_evt = (raw_i ^ prev_q) | extra_chg_i;
      assign view_o  = raw_i;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= next_flag(pend_q, set_evt, clr_i);
  end
  assign pend_o = pend_q;

  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> pend_q);
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_evt) |=> !pend_q);
endmodule

// File: rtl/rxsi_regif.sv
module rxsi_regif #(
  parameter int AW = 7,
  parameter int DW = 8,
  parameter logic [AW-1:0] STAT_ADDR = 7'h18,
  parameter logic [AW-1:0] MASK_ADDR = 7'h19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] status_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] mask_o,
  output logic          stat_rd_o
);
  logic          mask_wr;
  logic [DW-1:0] mask_q;

  assign mask_wr   = wr_i && (addr_i == MASK_ADDR);
  assign stat_rd_o = rd_i && (addr_i == STAT_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= wdata_i;
  end
  assign mask_o = mask_q;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (addr_i == STAT_ADDR)      rdata_o = status_i;
      else if (addr_i == MASK_ADDR) rdata_o = mask_q;
    end
  end

  assert_mask_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(wdata_i)));
  assert_mask_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));
endmodule

// File: rtl/rx_status_irq_regs.sv
module rx_status_irq_regs #(
  parameter int AW     = 7,
  parameter int KIND_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  input  logic              validity_i,
  input  logic              emphasis_i,
  input  logic              nonaudio_i,
  input  logic [KIND_W-1:0] nonaudio_kind_i,
  input  logic              preamble_i,
  input  logic              crc_err_i,
  input  logic              no_stream_i,
  input  logic              frame_err_i,
  input  logic              lock_i,
  output logic              irq_o
);
  import rxsi_pkg::*;

  logic [NBITS-1:0]  raw_vec;
  logic [NBITS-1:0]  extra_vec;
  logic [NBITS-1:0]  view_vec;
  logic [NBITS-1:0]  pend_vec;
  logic [NBITS-1:0]  mask_vec;
  logic              stat_rd;
  logic [KIND_W-1:0] kind_prev_q;
  logic              kind_chg;

  always_comb begin
    raw_vec          = '0;
    raw_vec[B_VALID] = validity_i;
    raw_vec[B_EMPH]  = emphasis_i;
    raw_vec[B_NAUD]  = nonaudio_i;
    raw_vec[B_PREAM] = preamble_i;
    raw_vec[B_CRC]   = crc_err_i;
    raw_vec[B_NOSTR] = no_stream_i;
    raw_vec[B_FRAME] = frame_err_i;
    raw_vec[B_LOCK]  = lock_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kind_prev_q <= '0;
    else        kind_prev_q <= nonaudio_kind_i;
  end
  assign kind_chg = nonaudio_i && (nonaudio_kind_i != kind_prev_q);

  always_comb begin
    extra_vec         = '0;
    extra_vec[B_NAUD] = kind_chg;
  end

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    rxsi_bit_cell #(.STICKY(STICKY_MAP[i])) u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .raw_i      (raw_vec[i]),
      .extra_chg_i(extra_vec[i]),
      .clr_i      (stat_rd),
      .view_o     (view_vec[i]),
      .pend_o     (pend_vec[i])
    );
  end

  rxsi_regif #(.AW(AW), .DW(NBITS)) u_regif (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (bus_addr_i),
    .rd_i     (bus_rd_i),
    .wr_i     (bus_wr_i),
    .wdata_i  (bus_wdata_i),
    .status_i (view_vec),
    .rdata_o  (bus_rdata_o),
    .mask_o   (mask_vec),
    .stat_rd_o(stat_rd)
  );

  assign irq_o = irq_reduce(pend_vec, mask_vec);

  assert_irq_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_vec == '0) |-> !irq_o);
  assert_kind_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kind_chg |=> pend_vec[B_NAUD]);
  assert_irq_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && raw_vec == $past(raw_vec) && !kind_chg && raw_vec[B_CRC] == 1'b0
     && raw_vec[B_FRAME] == 1'b0) |=> (pend_vec == '0));
endmodule

// File: tb/rx_status_irq_regs_tb_top.sv
module rx_status_irq_regs_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] bus_addr = '0;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       validity = 0, emphasis = 0, nonaudio = 0, preamble = 0;
  logic [1:0] kind = '0;
  logic       crc = 0, nostr = 0, frame = 0, lock = 0;
  logic       irq;
  int         checks = 0, errors = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  rx_status_irq_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr_i(bus_addr), .bus_rd_i(bus_rd),
    .bus_wr_i(bus_wr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .validity_i(validity), .emphasis_i(emphasis), .nonaudio_i(nonaudio),
    .nonaudio_kind_i(kind), .preamble_i(preamble), .crc_err_i(crc),
    .no_stream_i(nostr), .frame_err_i(frame), .lock_i(lock), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 irq", {7'b0, irq}, 8'h00);
    rd(7'h19, d); check("R1 mask", d, 8'h00);
    rd(7'h18, d); check("R1 status", d, 8'h00);
  endtask

  task automatic t_regmap();
    logic [7:0] d;
    wr(7'h19, 8'hA5); rd(7'h19, d); check("R2 mask rw", d, 8'hA5);
    wr(7'h18, 8'hFF); rd(7'h18, d); check("R2 status write ignored", d, 8'h00);
    check("R2 no irq from status write", {7'b0, irq}, 8'h00);
    rd(7'h1A, d); check("R2 unmapped", d, 8'h00);
    wr(7'h19, 8'hFF);
  endtask

  task automatic t_sticky();
    logic [7:0] d;
    @(negedge clk); crc = 1; @(negedge clk); crc = 0;
    check("R4 crc irq", {7'b0, irq}, 8'h01);
    step(3);
    @(negedge clk); frame = 1; @(negedge clk); frame = 0;
    rd(7'h18, d); check("R4 R3 sticky bits 3 and 1", d, 8'h0A);
    check("R4 irq cleared", {7'b0, irq}, 8'h00);
    rd(7'h18, d); check("R4 cleared by read", d, 8'h00);
  endtask

  task automatic t_cond_order();
    logic [7:0] d;
    logic [7:0] exp_bits [6] = '{8'h80, 8'h40, 8'h20, 8'h10, 8'h04, 8'h01};
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      {validity, emphasis, nonaudio, preamble, nostr, lock} = 6'b100000 >> k;
      @(negedge clk);
      check("R6 change irq", {7'b0, irq}, 8'h01);
      rd(7'h18, d); check("R3 R5 bit position", d, exp_bits[k]);
      step(4);
      check("R6 no re-irq while stable", {7'b0, irq}, 8'h00);
      rd(7'h18, d); check("R5 live level", d, exp_bits[k]);
      @(negedge clk); {validity, emphasis, nonaudio, preamble, nostr, lock} = '0;
      @(negedge clk);
      check("R6 falling change irq", {7'b0, irq}, 8'h01);
      rd(7'h18, d); check("R6 falling clears", d, 8'h00);
    end
  endtask

  task automatic t_kind();
    logic [7:0] d;
    @(negedge clk); nonaudio = 1; step(1); rd(7'h18, d);
    @(negedge clk); kind = 2'd2; @(negedge clk);
    check("R7 kind change while non-audio", {7'b0, irq}, 8'h01);
    rd(7'h18, d); check("R7 status", d, 8'h20);
    @(negedge clk); nonaudio = 0; @(negedge clk);
    check("R6 back to audio", {7'b0, irq}, 8'h01);
    rd(7'h18, d);
    @(negedge clk); kind = 2'd1; @(negedge clk);
    check("R7 kind change while audio ignored", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(7'h19, 8'h08);
    @(negedge clk); lock = 1; @(negedge clk);
    check("R8 masked lock", {7'b0, irq}, 8'h00);
    @(negedge clk); crc = 1; @(negedge clk); crc = 0;
    check("R8 enabled crc", {7'b0, irq}, 8'h01);
    wr(7'h19, 8'h00);
    check("R8 all blocked", {7'b0, irq}, 8'h00);
    wr(7'h19, 8'h01);
    check("R8 pending lock unmasked", {7'b0, irq}, 8'h01);
    rd(7'h18, d); check("R8 status", d, 8'h09);
    @(negedge clk); lock = 0; @(negedge clk); rd(7'h18, d);
    wr(7'h19, 8'hFF);
  endtask

  task automatic t_race_and_maskread();
    logic [7:0] d;
    @(negedge clk); bus_addr = 7'h18; bus_rd = 1; crc = 1;
    @(negedge clk); bus_rd = 0; crc = 0;
    check("R9 event wins irq", {7'b0, irq}, 8'h01);
    rd(7'h19, d);
    check("R10 mask read keeps irq", {7'b0, irq}, 8'h01);
    rd(7'h18, d); check("R9 sticky survived", d, 8'h08);
    check("R9 cleared after later read", {7'b0, irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_sticky();
    t_cond_order();
    t_kind();
    t_mask();
    t_race_and_maskread();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule